// File: doc/BRIEF.md
# Serial Bus Clock Generator

This block produces the serial clock of a two-wire bus controller from the peripheral clock. A 16-bit control word selects the timing. Bit 15 selects fast mode, bit 14 selects the duty ratio in fast mode, and bits 11:0 hold the divider. A separate rise-time value sets a minimum number of cycles between releasing the line and starting the high count. The block drives the line through an open-drain style output: it either pulls the line low or releases it. It never drives the line high.

A bit engine starts the generator with a start request. The generator then runs low and high phases in turn until a stop request has been seen. It then finishes the current high phase, leaves the line released and returns to idle. The high count begins only once the line has been sampled high, so a target that stretches the clock can hold the line low for as long as it needs. A one-cycle strobe in the middle of each low phase tells the bit engine when it may change the data line. A one-cycle strobe in the middle of each high phase tells it when to sample the data line. Timing settings are captured while the generator is idle and stay frozen for the whole run.

Top module: `scl_clkgen`

## Requirements
- R1: After reset, and while idle, `scl_pull_low` is 0 and neither strobe fires. The line stays released until a start is accepted.
- R2: A start request is accepted only when `enable` is 1 and the generator is idle. `scl_pull_low` is then 1 from the next cycle. A start given while `enable` is 0 is not remembered.
- R3: In standard mode (bit 15 = 0), with effective divider d, the low phase lasts d cycles and the high count lasts d cycles.
- R4: In fast mode (bit 15 = 1) with bit 14 = 0, the low phase lasts 2·d cycles and the high count lasts d cycles.
- R5: In fast mode with bit 14 = 1, the low phase lasts 16·d cycles and the high count lasts 9·d cycles.
- R6: The effective divider d is the divider field (bits 11:0), raised to 4 in standard mode and to 1 in fast mode when it is smaller.
- R7: After each release, the high count starts no sooner than `rise_time` cycles later (at least 1 cycle). The released time per period is therefore max(`rise_time`,1) plus the high count when the line follows the drive.
- R8: While `scl_in` is sampled low after a release, the high count does not start and no sample strobe fires. Once `scl_in` is sampled high, the high count runs for its full length.
- R9: `sda_change_stb` fires once per low phase, at low-phase cycle index floor(low/2). `sda_sample_stb` fires once per high count, at high-count cycle index floor(high/2). The two strobes never fire together.
- R10: A stop request seen while running lets the current or next high phase complete. The line then stays released and the generator goes idle. A stop request given while idle is ignored.
- R11: Changes to the control word or rise time while running do not affect the running clock.
- R12: Dropping `enable` returns the generator to idle and releases the line in the next cycle. Raising `enable` again does not restart the clock without a new start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Peripheral enable; low forces idle |
| ctl_word | input | 16 | [15] fast mode, [14] fast duty select, [11:0] divider |
| rise_time | input | RISE_W | Minimum released cycles before the high count |
| start_req | input | 1 | Request to start clocking |
| stop_req | input | 1 | Request to end clocking after a high phase |
| scl_in | input | 1 | Sampled level of the clock line |
| scl_pull_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_change_stb | output | 1 | Mid-low strobe: data line may change |
| sda_sample_stb | output | 1 | Mid-high strobe: data line may be sampled |

## Verification
`scl_pull_low` rises one cycle after the edge that samples an accepted start, and falls one cycle after the edge that samples a disable. Each phase boundary falls exactly one phase length, counted in whole cycles, after the previous one. The bench drives inputs and samples outputs on the falling clock edge. It therefore checks the pull-low level at the first falling edge after a start or a disable. It measures phases by counting falling edges at which the line is pulled or released, and records the index within the phase at which each strobe is seen. These counts are compared with lengths and midpoints computed from the divider, duty, floor and rise-time rules. Stretching is modelled by holding the line low from the bench for a fixed number of cycles. After the hold is released, the expected high count is measured from the first falling edge.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
   localparam int unsigned CTL_W      = 16;
   localparam int unsigned FAST_BIT   = 15;
   localparam int unsigned DUTY_BIT   = 14;
   localparam int unsigned STD_FLOOR  = 4;
   localparam int unsigned FAST_FLOOR = 1;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_RISE = 2'd2,
      PH_HIGH = 2'd3
   } scl_phase_e;
endpackage

// File: rtl/scl_period_calc.sv
module scl_period_calc
   import scl_gen_pkg::*;
#(
   parameter int unsigned DIV_W     = 12,
   parameter int unsigned RISE_W    = 6,
   parameter int unsigned LEN_W     = DIV_W + 5,
   parameter int unsigned MUL_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [CTL_W-1:0]  ctl_word,
   input  logic [RISE_W-1:0] rise_in,
   output logic [LEN_W-1:0]  low_len,
   output logic [LEN_W-1:0]  high_len,
   output logic [LEN_W-1:0]  rise_len
);
   initial begin : elab_chk
      assert (DIV_W >= 3 && DIV_W <= DUTY_BIT) else $fatal(1, "DIV_W out of range");
      assert (LEN_W >= DIV_W + 5) else $fatal(1, "LEN_W too narrow");
      assert (RISE_W <= LEN_W) else $fatal(1, "RISE_W wider than LEN_W");
   end

   logic              fast_sel, duty_sel;
   logic [LEN_W-1:0]  div_raw, floor_val, d_eff;
   logic [LEN_W-1:0]  low_next, high_next;
   logic              fast_q, duty_q;

   assign fast_sel  = ctl_word[FAST_BIT];
   assign duty_sel  = ctl_word[DUTY_BIT];
   assign div_raw   = LEN_W'(ctl_word[DIV_W-1:0]);
   assign floor_val = fast_sel ? LEN_W'(FAST_FLOOR) : LEN_W'(STD_FLOOR);
   assign d_eff     = (div_raw < floor_val) ? floor_val : div_raw;

   generate
      if (DIV_W < DUTY_BIT) begin : g_spare
         logic unused_spare;
         assign unused_spare = ^ctl_word[DUTY_BIT-1:DIV_W];
      end

      if (MUL_STYLE == 0) begin : g_shift_add
         always_comb begin
            if (!fast_sel) begin
               low_next  = d_eff;
               high_next = d_eff;
            end else if (!duty_sel) begin
               low_next  = d_eff << 1;
               high_next = d_eff;
            end else begin
               low_next  = d_eff << 4;
               high_next = (d_eff << 3) + d_eff;
            end
         end
      end else begin : g_multiply
         always_comb begin
            if (!fast_sel) begin
               low_next  = d_eff;
               high_next = d_eff;
            end else if (!duty_sel) begin
               low_next  = LEN_W'(2) * d_eff;
               high_next = d_eff;
            end else begin
               low_next  = LEN_W'(16) * d_eff;
               high_next = LEN_W'(9) * d_eff;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_len  <= LEN_W'(STD_FLOOR);
         high_len <= LEN_W'(STD_FLOOR);
         rise_len <= LEN_W'(1);
         fast_q   <= 1'b0;
         duty_q   <= 1'b0;
      end else if (capture) begin
         low_len  <= low_next;
         high_len <= high_next;
         rise_len <= LEN_W'(rise_in);
         fast_q   <= fast_sel;
         duty_q   <= duty_sel;
      end
   end

   // R6 / R3: standard mode keeps a symmetric clock at or above the floor
   a_r6_std_floor: assert property (@(posedge clk) disable iff (!rst_n)
      !fast_q |-> (low_len >= LEN_W'(STD_FLOOR)) && (high_len == low_len));
   // R4: fast mode, ratio 2:1
   a_r4_ratio_two: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_q && !duty_q) |-> (low_len == (high_len << 1)) && (high_len != '0));
   // R5: fast mode, ratio 16:9
   a_r5_ratio_16_9: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_q && duty_q) |-> ((low_len >> 4) == (high_len / LEN_W'(9))) && (high_len != '0));
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
   import scl_gen_pkg::*;
#(
   parameter int unsigned LEN_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic             scl_in,
   input  logic [LEN_W-1:0] low_len,
   input  logic [LEN_W-1:0] high_len,
   input  logic [LEN_W-1:0] rise_len,
   output scl_phase_e       phase,
   output logic [LEN_W-1:0] cnt
);
   logic             stop_pend;
   logic             rise_met;
   logic             low_last, high_last;
   logic [LEN_W-1:0] cnt_inc;

   assign cnt_inc   = cnt + LEN_W'(1);
   assign rise_met  = cnt_inc >= rise_len;
   assign low_last  = cnt == (low_len - LEN_W'(1));
   assign high_last = cnt == (high_len - LEN_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         stop_pend <= 1'b0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               stop_pend <= 1'b0;
               cnt       <= '0;
               if (start_req) phase <= PH_LOW;
            end
            PH_LOW: begin
               if (stop_req) stop_pend <= 1'b1;
               if (low_last) begin
                  phase <= PH_RISE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt_inc;
               end
            end
            PH_RISE: begin
               if (stop_req) stop_pend <= 1'b1;
               if (rise_met && scl_in) begin
                  phase <= PH_HIGH;
                  cnt   <= '0;
               end else if (!rise_met) begin
                  cnt <= cnt_inc;
               end
            end
            PH_HIGH: begin
               if (high_last) begin
                  cnt <= '0;
                  if (stop_pend || stop_req) begin
                     phase     <= PH_IDLE;
                     stop_pend <= 1'b0;
                  end else begin
                     phase <= PH_LOW;
                  end
               end else begin
                  cnt <= cnt_inc;
                  if (stop_req) stop_pend <= 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R2: a new low phase follows only a start request or a completed high phase
   a_r2_low_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOW && $past(phase) != PH_LOW) |->
         ($past(start_req) || $past(phase) == PH_HIGH));
   // R8: a low line keeps the generator out of the high count
   a_r8_hold_blocks_high: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RISE && !scl_in && enable) |=> phase != PH_HIGH);
   // R3: the low-phase counter stays inside the programmed length
   a_r3_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_LOW |-> cnt < low_len);
   // R10: a pending stop ends the run when the high phase completes
   a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HIGH && stop_pend && high_last && enable) |=> phase == PH_IDLE);
endmodule

// File: rtl/scl_mid_strobe.sv
module scl_mid_strobe
   import scl_gen_pkg::*;
#(
   parameter int unsigned LEN_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  scl_phase_e       phase,
   input  logic [LEN_W-1:0] cnt,
   input  logic [LEN_W-1:0] low_len,
   input  logic [LEN_W-1:0] high_len,
   output logic             change_stb,
   output logic             sample_stb
);
   logic [LEN_W-1:0] low_mid, high_mid;

   assign low_mid    = low_len >> 1;
   assign high_mid   = high_len >> 1;
   assign change_stb = (phase == PH_LOW)  && (cnt == low_mid);
   assign sample_stb = (phase == PH_HIGH) && (cnt == high_mid);

   // R9: the two strobes never coincide
   a_r9_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(change_stb && sample_stb));
   // R9: a strobe is a single-cycle pulse
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (change_stb || sample_stb) |=> !(change_stb || sample_stb));
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
   import scl_gen_pkg::*;
#(
   parameter int unsigned DIV_W     = 12,
   parameter int unsigned RISE_W    = 6,
   parameter int unsigned MUL_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [15:0]       ctl_word,
   input  logic [RISE_W-1:0] rise_time,
   input  logic              start_req,
   input  logic              stop_req,
   input  logic              scl_in,
   output logic              scl_pull_low,
   output logic              sda_change_stb,
   output logic              sda_sample_stb
);
   localparam int unsigned LEN_W = DIV_W + 5;

   scl_phase_e       phase;
   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] low_len, high_len, rise_len;
   logic             capture;

   assign capture      = phase == PH_IDLE;
   assign scl_pull_low = phase == PH_LOW;

   scl_period_calc #(
      .DIV_W(DIV_W), .RISE_W(RISE_W), .LEN_W(LEN_W), .MUL_STYLE(MUL_STYLE)
   ) u_calc (
      .clk(clk), .rst_n(rst_n), .capture(capture),
      .ctl_word(ctl_word), .rise_in(rise_time),
      .low_len(low_len), .high_len(high_len), .rise_len(rise_len)
   );

   scl_phase_seq #(.LEN_W(LEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .start_req(start_req), .stop_req(stop_req), .scl_in(scl_in),
      .low_len(low_len), .high_len(high_len), .rise_len(rise_len),
      .phase(phase), .cnt(cnt)
   );

   scl_mid_strobe #(.LEN_W(LEN_W)) u_stb (
      .clk(clk), .rst_n(rst_n), .phase(phase), .cnt(cnt),
      .low_len(low_len), .high_len(high_len),
      .change_stb(sda_change_stb), .sample_stb(sda_sample_stb)
   );

   // R12: disable releases the line on the next cycle
   a_r12_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !scl_pull_low);
   // R9: the change strobe only appears while the line is pulled low
   a_r9_change_in_low: assert property (@(posedge clk) disable iff (!rst_n)
      sda_change_stb |-> scl_pull_low);
   // R1: an idle, disabled generator keeps the line released
   a_r1_released_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !$past(enable)) |-> !scl_pull_low);
endmodule

// File: tb/scl_clkgen_bench.sv
module scl_clkgen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b1;
   logic        start_req = 1'b0;
   logic        stop_req = 1'b0;
   logic        hold = 1'b0;
   logic [15:0] ctl = 16'h0004;
   logic [5:0]  rise = 6'd1;
   wire         scl_pull_low, chg, smp;
   wire         scl_in = ~scl_pull_low & ~hold;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   always #5 clk = ~clk;

   scl_clkgen u_scl_clkgen (
      .clk(clk), .rst_n(rst_n), .enable(enable), .ctl_word(ctl),
      .rise_time(rise), .start_req(start_req), .stop_req(stop_req),
      .scl_in(scl_in), .scl_pull_low(scl_pull_low),
      .sda_change_stb(chg), .sda_sample_stb(smp)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(input bit f, input bit dt, input int d);
      return {f, dt, 2'b00, d[11:0]};
   endfunction

   task automatic set_cfg(input bit f, input bit dt, input int d, input int r);
      ctl  = mk(f, dt, d);
      rise = r[5:0];
   endtask

   task automatic go_idle();
      @(negedge clk);
      enable = 1'b0; start_req = 1'b0; stop_req = 1'b0; hold = 1'b0;
      @(negedge clk);
      enable = 1'b1;
   endtask

   task automatic start_pulse(input string req);
      @(negedge clk) start_req = 1'b1;
      @(negedge clk) start_req = 1'b0;
      chk(req, int'(scl_pull_low), 1);
   endtask

   task automatic measure(output int lo, output int rel, output int chg_at,
                          output int smp_at, output int nchg, output int nsmp);
      int guard = 0;
      lo = 0; rel = 0; chg_at = -1; smp_at = -1; nchg = 0; nsmp = 0;
      while (scl_pull_low !== 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
      while (scl_pull_low === 1'b1 && guard < 4000) begin
         if (chg) begin nchg++; chg_at = lo; end
         if (smp) nsmp++;
         lo++; @(negedge clk); guard++;
      end
      while (scl_pull_low === 1'b0 && guard < 4000) begin
         if (smp) begin nsmp++; smp_at = rel; end
         if (chg) nchg++;
         rel++; @(negedge clk); guard++;
      end
   endtask

   task automatic window(input int n, output int lows, output int nchg, output int nsmp);
      lows = 0; nchg = 0; nsmp = 0;
      repeat (n) begin
         @(negedge clk);
         if (scl_pull_low) lows++;
         if (chg) nchg++;
         if (smp) nsmp++;
      end
   endtask

   task automatic check_period(input string req, input int e_lo, input int e_rel,
                               input int e_chg, input int e_smp);
      int lo, rel, ca, sa, nc, ns;
      measure(lo, rel, ca, sa, nc, ns);
      chk({req, " low length"}, lo, e_lo);
      chk({req, " released length"}, rel, e_rel);
      chk({req, " R9 change index"}, ca, e_chg);
      chk({req, " R9 sample index"}, sa, e_smp);
      chk({req, " R9 change count"}, nc, 1);
      chk({req, " R9 sample count"}, ns, 1);
   endtask

   task automatic t_reset();
      int l, c, s;
      chk("R1 reset pull", int'(scl_pull_low), 0);
      chk("R1 reset change", int'(chg), 0);
      chk("R1 reset sample", int'(smp), 0);
      window(20, l, c, s);
      chk("R1 idle lows", l, 0);
      chk("R1 idle strobes", c + s, 0);
   endtask

   task automatic t_start_disabled();
      int l, c, s;
      go_idle();
      @(negedge clk) begin enable = 1'b0; start_req = 1'b1; end
      @(negedge clk) start_req = 1'b0;
      window(10, l, c, s);
      chk("R2 start while disabled", l, 0);
      enable = 1'b1;
      window(10, l, c, s);
      chk("R2 start not remembered", l, 0);
   endtask

   task automatic t_standard();
      go_idle();
      set_cfg(0, 0, 6, 3);
      start_pulse("R2 start accepted");
      check_period("R3 std d6", 6, 9, 3, 6);
      check_period("R3 std d6 repeat", 6, 9, 3, 6);
   endtask

   task automatic t_fast_two();
      go_idle();
      set_cfg(1, 0, 3, 2);
      start_pulse("R2 start fast");
      check_period("R4 fast 2:1 d3", 6, 5, 3, 3);
   endtask

   task automatic t_fast_169();
      go_idle();
      set_cfg(1, 1, 2, 1);
      start_pulse("R2 start fast169");
      check_period("R5 fast 16:9 d2", 32, 19, 16, 10);
   endtask

   task automatic t_floor();
      go_idle();
      set_cfg(0, 0, 1, 1);
      start_pulse("R2 start floor std");
      check_period("R6 std floor", 4, 5, 2, 3);
      go_idle();
      set_cfg(1, 0, 0, 1);
      start_pulse("R2 start floor fast");
      check_period("R6 fast floor", 2, 2, 1, 1);
   endtask

   task automatic t_rise();
      go_idle();
      set_cfg(0, 0, 4, 10);
      start_pulse("R2 start rise10");
      check_period("R7 rise 10", 4, 14, 2, 12);
      go_idle();
      set_cfg(0, 0, 4, 0);
      start_pulse("R2 start rise0");
      check_period("R7 rise 0", 4, 5, 2, 3);
   endtask

   task automatic t_stretch();
      int l, c, s, rel, sa, guard;
      go_idle();
      set_cfg(0, 0, 4, 2);
      start_pulse("R2 start stretch");
      guard = 0;
      while (scl_pull_low === 1'b1 && guard < 100) begin @(negedge clk); guard++; end
      hold = 1'b1;
      window(20, l, c, s);
      chk("R8 held lows", l, 0);
      chk("R8 no sample while held", s, 0);
      hold = 1'b0;
      @(negedge clk);
      rel = 0; sa = -1; guard = 0;
      while (scl_pull_low === 1'b0 && guard < 100) begin
         if (smp) sa = rel;
         rel++; @(negedge clk); guard++;
      end
      chk("R8 high after release", rel, 4);
      chk("R8 R9 sample index", sa, 2);
   endtask

   task automatic t_stop();
      int l, c, s;
      go_idle();
      set_cfg(0, 0, 4, 1);
      @(negedge clk) start_req = 1'b1;
      @(negedge clk) begin start_req = 1'b0; stop_req = 1'b1; end
      @(negedge clk) stop_req = 1'b0;
      window(100, l, c, s);
      chk("R10 remaining lows", l, 2);
      chk("R10 one change", c, 1);
      chk("R10 one sample", s, 1);
      chk("R10 released after stop", int'(scl_pull_low), 0);
   endtask

   task automatic t_idle_stop();
      int l, c, s;
      go_idle();
      set_cfg(0, 0, 4, 1);
      @(negedge clk) stop_req = 1'b1;
      @(negedge clk) stop_req = 1'b0;
      start_pulse("R2 start after idle stop");
      window(90, l, c, s);
      chk("R10 idle stop ignored", l, 40);
   endtask

   task automatic t_freeze_disable();
      int l, c, s;
      go_idle();
      set_cfg(0, 0, 5, 1);
      start_pulse("R2 start freeze");
      set_cfg(1, 1, 10, 30);
      check_period("R11 frozen", 5, 6, 2, 3);
      check_period("R11 frozen repeat", 5, 6, 2, 3);
      @(negedge clk) enable = 1'b0;
      @(negedge clk);
      chk("R12 disable releases", int'(scl_pull_low), 0);
      enable = 1'b1;
      window(40, l, c, s);
      chk("R12 no restart", l, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog all actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_start_disabled();
      t_standard();
      t_fast_two();
      t_fast_169();
      t_floor();
      t_rise();
      t_stretch();
      t_stop();
      t_idle_stop();
      t_freeze_disable();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule